// File: doc/BRIEF.md
# Power-to-Pulse-Rate Converter

This block turns a stream of signed real-power samples, which arrive already multiplied and low-pass filtered, into pulse trains whose rate follows the average real power. Each valid sample is added by magnitude into an energy accumulator. Each time the accumulated energy passes a threshold, one pulse goes out on a fast calibration output. Two slow outputs give one pulse for every fixed power-of-two number of fast pulses. The averaging comes from the accumulation itself, so a meter or a counter downstream only has to count edges over a timing window.

A two-bit rate select picks the slow full-scale rate as a binary fraction of the master clock. A one-bit scale select picks how many times faster than the slow outputs the fast output runs. Negative power goes into a second accumulator of its own, so pulses keep coming under reverse flow, and a direction flag shows the sign of the latest sample. The two slow outputs are non-overlapping and run half a slow period apart, which suits a two-phase stepper counter.

Top module: `pwr_pulse_conv`

## Requirements
- R1: With fast threshold T = 2^(PW-1+LF_SHIFT-rate_sel-k), where k is CF_SH0 when cf_scale is 0 and CF_SH1 when it is 1, a run of N valid samples of magnitude P from reset gives exactly floor(N*P/T) falling edges on cf_n. The remainder is kept between samples.
- R2: The slow threshold is 2^(PW-1+LF_SHIFT-rate_sel), so rate_sel codes 0,1,2,3 make a full-scale input give f_clk/2^(LF_SHIFT), /2^(LF_SHIFT-1), /2^(LF_SHIFT-2) and /2^(LF_SHIFT-3) on f1_n.
- R3: The fast output runs at 2^CF_SH0 times the slow rate when cf_scale is 0 and at 2^CF_SH1 times when it is 1. The slow rate does not depend on cf_scale.
- R4: Each cf_n pulse is low for exactly CF_WIDTH clocks and then returns high.
- R5: f1_n goes low for exactly F_WIDTH clocks after every M = 2^k fast events, counted from reset. So C fast events give floor(C/M) f1_n pulses.
- R6: f2_n pulses, F_WIDTH clocks low, come after fast event M/2 and every M events after that, so C events give floor((C+M/2)/M) pulses. f1_n and f2_n are never low together, and an f2_n edge leads the next f1_n edge by M/2 fast-event intervals.
- R7: Negative samples add their magnitude into a reverse accumulator that is separate from the forward one. Both feed the same pulse outputs, and neither accumulator's remainder is affected by samples of the other sign.
- R8: revp is 1 from the clock after a valid negative sample. It is 0 from the clock after a valid zero or positive sample, and holds between valid samples.
- R9: A zero-valued sample, or any sample presented with sample_vld low, produces no pulse and leaves both accumulators unchanged.
- R10: A synchronous active-high rst clears both accumulators and the slow-event divider, drives f1_n, f2_n and cf_n high and revp low.
- R11: rate_sel and cf_scale are static: they change only while rst is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_vld | input | 1 | Sample valid strobe |
| sample | input | PW | Signed real-power sample |
| rate_sel | input | 2 | Slow-rate select (binary fraction of clock) |
| cf_scale | input | 1 | Fast-output multiple select |
| f1_n | output | 1 | Slow pulse output, active low |
| f2_n | output | 1 | Slow pulse output, half a period after f1_n, active low |
| cf_n | output | 1 | Fast calibration pulse output, active low |
| revp | output | 1 | Reverse power flag |

## Verification
The embedded properties assume three things about the inputs. The two select inputs move only under reset. Pulse events arrive no faster than the pulse widths allow, so no output is retriggered while it is still low. The parameters keep the largest sample magnitude at or below the smallest fast threshold, so one sample crosses at most once. The stimulus holds the selects fixed inside each reset window. It uses bench parameters whose widths are shorter than the smallest event spacing that the chosen magnitudes can produce, at most 128 against a fast threshold of 256 or more. Pulses are counted only after a tail of idle cycles, so the counts do not depend on pipeline latency.

// File: rtl/pwrconv_pkg.sv
package pwrconv_pkg;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_REV = 1'b1
    } flow_dir_e;

    typedef struct packed {
        logic f1;
        logic f2;
    } slow_evt_t;

    typedef struct packed {
        flow_dir_e dir;
        logic      nonzero;
    } sample_info_t;

    function automatic int pick_cf_shift(logic scale, int sh0, int sh1);
        return scale ? sh1 : sh0;
    endfunction

    function automatic int fast_thr_shift(int base, logic [1:0] sel, int cfsh);
        return base - int'(sel) - cfsh;
    endfunction

endpackage

// File: rtl/pf_accum.sv
module pf_accum #(
    parameter int PW    = 16,
    parameter int ACC_W = 37
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             add_en,
    input  logic [PW-1:0]    mag,
    input  logic [ACC_W-1:0] thr,
    output logic             evt
);
    localparam int SW = ACC_W + 1;

    logic [ACC_W-1:0] acc;
    logic [SW-1:0]    sum;
    logic             crossing;

    always_comb begin
        sum      = {1'b0, acc} + {1'b0, ACC_W'(mag)};
        crossing = (sum >= {1'b0, thr});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            evt <= 1'b0;
        end else begin
            evt <= add_en && crossing;
            if (add_en) begin
                if (crossing)
                    acc <= ACC_W'(sum - {1'b0, thr});
                else
                    acc <= ACC_W'(sum);
            end
        end
    end

    // R1: remainder always stays under the active threshold
    a_r1_remainder_below_thr: assert property (@(posedge clk) disable iff (rst)
        acc < thr);

    // R9: without an add the stored energy does not move
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !add_en |=> $stable(acc));

endmodule

// File: rtl/pf_divider.sv
module pf_divider
    import pwrconv_pkg::*;
#(
    parameter int SH0   = 11,
    parameter int SH1   = 10,
    parameter int CNT_W = 12
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cf_evt,
    input  logic      scale,
    output slow_evt_t sevt
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] modulus;
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        modulus = CNT_W'(1) << pick_cf_shift(scale, SH0, SH1);
        half    = modulus >> 1;
        cnt_nx  = cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            sevt <= '0;
        end else begin
            sevt <= '0;
            if (cf_evt) begin
                if (cnt_nx == modulus) begin
                    cnt     <= '0;
                    sevt.f1 <= 1'b1;
                end else begin
                    cnt <= cnt_nx;
                end
                if (cnt_nx == half)
                    sevt.f2 <= 1'b1;
            end
        end
    end

    // R6: the two slow phases never fire in the same cycle
    a_r6_phase_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(sevt.f1 && sevt.f2));

    // R5: the event count never reaches the modulus
    a_r5_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt < modulus);

endmodule

// File: rtl/pf_pulse.sv
module pf_pulse #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic out_n
);
    localparam int CW = (W < 2) ? 1 : $clog2(W + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (trig)
            cnt <= CW'(W);
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign out_n = (cnt == '0);

    // R4: a new trigger arrives only once the previous pulse has ended
    a_r4_no_retrigger: assert property (@(posedge clk) disable iff (rst)
        trig |-> cnt == '0);

    // R4: a trigger always pulls the output low on the next cycle
    a_r4_trig_low: assert property (@(posedge clk) disable iff (rst)
        trig |=> !out_n);

    generate
        if (W > 1) begin : g_wide
            // R4: a wide pulse lasts past its first low cycle
            a_r4_min_width: assert property (@(posedge clk) disable iff (rst)
                $fell(out_n) |=> !out_n);
        end
    endgenerate

endmodule

// File: rtl/pwr_pulse_conv.sv
module pwr_pulse_conv
    import pwrconv_pkg::*;
#(
    parameter int PW       = 16,
    parameter int LF_SHIFT = 21,
    parameter int CF_SH0   = 11,
    parameter int CF_SH1   = 10,
    parameter int F_WIDTH  = 64,
    parameter int CF_WIDTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample_vld,
    input  logic [PW-1:0] sample,
    input  logic [1:0]    rate_sel,
    input  logic          cf_scale,
    output logic          f1_n,
    output logic          f2_n,
    output logic          cf_n,
    output logic          revp
);
    localparam int BASE   = PW - 1 + LF_SHIFT;
    localparam int ACC_W  = BASE + 1;
    localparam int SH_MAX = (CF_SH0 > CF_SH1) ? CF_SH0 : CF_SH1;
    localparam int CNT_W  = SH_MAX + 1;
    localparam int NDIR   = 2;

    sample_info_t     info;
    logic [PW-1:0]    mag;
    logic [ACC_W-1:0] cf_thr;
    logic [NDIR-1:0]  dir_evt;
    logic             cf_evt;
    slow_evt_t        sevt;
    logic [1:0]       slow_trig;
    logic [1:0]       slow_n;

    always_comb begin
        info.dir     = sample[PW-1] ? DIR_REV : DIR_FWD;
        info.nonzero = (sample != '0);
        mag          = sample[PW-1] ? (~sample + PW'(1)) : sample;
        cf_thr       = ACC_W'(1) << fast_thr_shift(BASE, rate_sel,
                           pick_cf_shift(cf_scale, CF_SH0, CF_SH1));
    end

    generate
        for (genvar d = 0; d < NDIR; d++) begin : g_dir
            logic add_en;
            assign add_en = sample_vld && info.nonzero &&
                            (info.dir == flow_dir_e'(d));
            pf_accum #(.PW(PW), .ACC_W(ACC_W)) u_acc (
                .clk    (clk),
                .rst    (rst),
                .add_en (add_en),
                .mag    (mag),
                .thr    (cf_thr),
                .evt    (dir_evt[d])
            );
        end
    endgenerate

    assign cf_evt = |dir_evt;

    pf_divider #(.SH0(CF_SH0), .SH1(CF_SH1), .CNT_W(CNT_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .cf_evt (cf_evt),
        .scale  (cf_scale),
        .sevt   (sevt)
    );

    pf_pulse #(.W(CF_WIDTH)) u_cf (
        .clk   (clk),
        .rst   (rst),
        .trig  (cf_evt),
        .out_n (cf_n)
    );

    assign slow_trig = {sevt.f2, sevt.f1};

    generate
        for (genvar p = 0; p < 2; p++) begin : g_slow
            pf_pulse #(.W(F_WIDTH)) u_sp (
                .clk   (clk),
                .rst   (rst),
                .trig  (slow_trig[p]),
                .out_n (slow_n[p])
            );
        end
    endgenerate

    assign f1_n = slow_n[0];
    assign f2_n = slow_n[1];

    always_ff @(posedge clk) begin
        if (rst)
            revp <= 1'b0;
        else if (sample_vld)
            revp <= (info.dir == DIR_REV);
    end

    // R1: the two direction accumulators never cross together
    a_r1_single_crossing: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dir_evt));

    // R6: slow outputs are never low at the same time
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
        f1_n || f2_n);

    // R8: a negative sample raises the flag
    a_r8_revp_set: assert property (@(posedge clk) disable iff (rst)
        (sample_vld && sample[PW-1]) |=> revp);

    // R8: a non-negative sample clears the flag
    a_r8_revp_clr: assert property (@(posedge clk) disable iff (rst)
        (sample_vld && !sample[PW-1]) |=> !revp);

    // R11: selects are held while out of reset
    a_r11_sel_static: assert property (@(posedge clk) disable iff (rst)
        $stable(rate_sel) && $stable(cf_scale));

endmodule

// File: tb/sim_pwr_pulse_conv.sv
`timescale 1ns/1ps
module sim_pwr_pulse_conv;
    localparam int PW       = 8;
    localparam int LF_SHIFT = 6;
    localparam int CF_SH0   = 2;
    localparam int CF_SH1   = 1;
    localparam int F_WIDTH  = 3;
    localparam int CF_WIDTH = 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sample_vld = 1'b0;
    logic [PW-1:0] sample = '0;
    logic [1:0]    rate_sel = 2'd3;
    logic          cf_scale = 1'b0;
    logic          f1_n, f2_n, cf_n, revp;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int cnt_cf, cnt_f1, cnt_f2;
    int run_cf, run_f1, last_cf_w, last_f1_w;
    int first_f1, first_f2;
    logic p_cf, p_f1, p_f2;

    always #10 clk = ~clk;

    pwr_pulse_conv #(
        .PW(PW), .LF_SHIFT(LF_SHIFT), .CF_SH0(CF_SH0), .CF_SH1(CF_SH1),
        .F_WIDTH(F_WIDTH), .CF_WIDTH(CF_WIDTH)
    ) u0 (
        .clk(clk), .rst(rst), .sample_vld(sample_vld), .sample(sample),
        .rate_sel(rate_sel), .cf_scale(cf_scale),
        .f1_n(f1_n), .f2_n(f2_n), .cf_n(cf_n), .revp(revp)
    );

    task automatic clear_mon();
        cnt_cf = 0; cnt_f1 = 0; cnt_f2 = 0;
        run_cf = 0; run_f1 = 0; last_cf_w = 0; last_f1_w = 0;
        first_f1 = -1; first_f2 = -1;
        p_cf = 1'b1; p_f1 = 1'b1; p_f2 = 1'b1;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (p_cf && !cf_n) cnt_cf++;
            if (p_f1 && !f1_n) begin
                cnt_f1++;
                if (first_f1 < 0) first_f1 = cyc;
            end
            if (p_f2 && !f2_n) begin
                cnt_f2++;
                if (first_f2 < 0) first_f2 = cyc;
            end
            if (!cf_n) run_cf++;
            else if (run_cf != 0) begin last_cf_w = run_cf; run_cf = 0; end
            if (!f1_n) run_f1++;
            else if (run_f1 != 0) begin last_f1_w = run_f1; run_f1 = 0; end
            p_cf = cf_n; p_f1 = f1_n; p_f2 = f2_n;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] sel, input logic scl);
        @(negedge clk);
        rst = 1'b1; sample_vld = 1'b0; sample = '0;
        rate_sel = sel; cf_scale = scl;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        clear_mon();
    endtask

    task automatic feed(input int val, input int n, input bit vld);
        for (int i = 0; i < n; i++) begin
            sample_vld = vld; sample = PW'(val);
            @(negedge clk);
        end
        sample_vld = 1'b0;
    endtask

    task automatic settle();
        repeat (40) @(negedge clk);
    endtask

    // fast threshold and divider modulus from R1/R3
    function automatic int fast_thr(input int sel, input int scl);
        return 1 << (PW - 1 + LF_SHIFT - sel - (scl ? CF_SH1 : CF_SH0));
    endfunction

    task automatic expect_counts(input int p, input int n, input int sel, input int scl,
                                 input string tag);
        int c, m;
        c = (n * p) / fast_thr(sel, scl);
        m = 1 << (scl ? CF_SH1 : CF_SH0);
        check(cnt_cf == c, {tag, " R1 cf count"}, cnt_cf, c);
        check(cnt_f1 == c / m, {tag, " R5 f1 count"}, cnt_f1, c / m);
        check(cnt_f2 == (c + m / 2) / m, {tag, " R6 f2 count"}, cnt_f2, (c + m / 2) / m);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(f1_n && f2_n && cf_n, "R10 outputs high in reset", {f1_n, f2_n, cf_n}, 7);
        check(!revp, "R10 revp low in reset", revp, 0);
    endtask

    task automatic t_full_scale_fast();
        do_reset(2'd3, 1'b0);
        feed(-128, 1, 1'b1);
        @(negedge clk);
        check(revp, "R8 revp after negative", revp, 1);
        do_reset(2'd3, 1'b0);
        feed(127, 1, 1'b1);
        feed(1, 63, 1'b1);
        do_reset(2'd3, 1'b0);
        feed(-128, 64, 1'b1);
        settle();
        expect_counts(128, 64, 3, 0, "fullscale sel3");
        check(last_cf_w == CF_WIDTH, "R4 cf low width", last_cf_w, CF_WIDTH);
        check(last_f1_w == F_WIDTH, "R5 f1 low width", last_f1_w, F_WIDTH);
        check(first_f1 - first_f2 == 4, "R6 f2 leads f1 by half period", first_f1 - first_f2, 4);
        check(revp, "R7 revp held under reverse flow", revp, 1);
    endtask

    task automatic t_rate_sel0();
        do_reset(2'd0, 1'b0);
        feed(128 - 1, 512, 1'b1);
        settle();
        expect_counts(127, 512, 0, 0, "R2 sel0");
        do_reset(2'd1, 1'b0);
        feed(-128, 256, 1'b1);
        settle();
        expect_counts(128, 256, 1, 0, "R2 sel1");
    endtask

    task automatic t_scale1();
        do_reset(2'd3, 1'b1);
        feed(-128, 64, 1'b1);
        settle();
        expect_counts(128, 64, 3, 1, "R3 scale1");
        check(cnt_f1 == 8, "R3 slow rate independent of scale", cnt_f1, 8);
    endtask

    task automatic t_fraction();
        do_reset(2'd3, 1'b0);
        feed(100, 50, 1'b1);
        settle();
        expect_counts(100, 50, 3, 0, "R1 fractional");
        check(!revp, "R8 revp low after positive", revp, 0);
    endtask

    task automatic t_zero_invalid();
        do_reset(2'd3, 1'b0);
        feed(-100, 1, 1'b1);
        feed(0, 100, 1'b1);
        settle();
        check(cnt_cf == 0, "R9 zero samples give no pulse", cnt_cf, 0);
        check(!revp, "R8 zero sample clears revp", revp, 0);
        feed(127, 100, 1'b0);
        settle();
        check(cnt_cf == 0, "R9 invalid samples give no pulse", cnt_cf, 0);
        // remainder must still be 100 (from the negative sample only in reverse acc)
        feed(-100, 1, 1'b1);
        feed(-56, 1, 1'b1);
        settle();
        check(cnt_cf == 1, "R9 reverse remainder untouched", cnt_cf, 1);
    endtask

    task automatic t_split_acc();
        do_reset(2'd3, 1'b0);
        feed(96, 2, 1'b1);
        feed(-96, 2, 1'b1);
        settle();
        check(cnt_cf == 0, "R7 no crossing below threshold", cnt_cf, 0);
        feed(96, 1, 1'b1);
        settle();
        check(cnt_cf == 1, "R7 forward remainder kept", cnt_cf, 1);
        feed(-96, 1, 1'b1);
        settle();
        check(cnt_cf == 2, "R7 reverse remainder kept", cnt_cf, 2);
    endtask

    initial begin
        clear_mon();
        t_reset_state();
        t_full_scale_fast();
        t_rate_sel0();
        t_scale1();
        t_fraction();
        t_zero_invalid();
        t_split_acc();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule